// File: doc/BRIEF.md
# Low-Rate Direct-Sequence Transmit Encoder

This block is the digital transmit chain for the 1 and 2 Mbps direct-sequence spread-spectrum modes. A frame is started by a one-cycle `start` pulse. The block then emits a short preamble of three sections. First comes a synchronisation field of zero data bits at one bit per symbol. The start-of-frame delimiter follows at the same rate. Last comes a header word, supplied on an input port, at two bits per symbol. After the preamble the block pulls payload bytes from a valid/ready stream at the rate chosen by `pay_2m`. The frame ends at the first byte slot where no byte is offered.

Every data bit passes through a self-synchronising scrambler. The scrambler divides by 1 + x^-4 + x^-7 and its register is loaded from `seed` when the frame starts. The scrambled bits are differentially encoded onto a four-state carrier phase, which is reset to 0° at the start of each frame. Each symbol is then spread by an 11-chip sequence. The result is one I/Q chip pair after every `chip_en` pulse, which the downstream chip-rate logic consumes.

Top module: `dsss_lr_tx`

## Requirements
- R1: After reset, `chip_valid`, `busy` and `s_ready` are all 0.
- R2: A `start` pulse while idle latches `seed`, `hdr_word` and `pay_2m` and starts a frame. A `start` pulse during a frame has no effect on its chip stream.
- R3: Each symbol lasts 11 chips. The spreading sequence is +1 -1 +1 +1 -1 +1 +1 +1 -1 -1 -1, sent first element first. A chip is produced for each `chip_en` during a frame and appears on `chip_i`/`chip_q` with `chip_valid` high in the following cycle. An output bit of 1 means +1 and 0 means -1.
- R4: Each data bit d is scrambled to s = d XOR r[3] XOR r[6], and then r shifts to {r[5:0], s}. `seed` loads r at frame start, with r[0] holding the most recent output.
- R5: A frame opens with 56 one-bit symbols whose unscrambled data bits are 0.
- R6: The delimiter 0x05CF follows at one bit per symbol, least-significant bit first.
- R7: The 48-bit `hdr_word` follows at two bits per symbol, least-significant bit first. The earlier bit is the first bit of each pair.
- R8: For one-bit symbols, scrambled bit 0 leaves the phase unchanged and 1 adds 180°. Phase maps to (I,Q) signs as 0°:(+,+), 90°:(-,+), 180°:(-,-), 270°:(+,-).
- R9: For two-bit symbols, the scrambled pair (first,second) adds 00:0°, 01:+90°, 11:180°, 10:-90°.
- R10: Payload bytes are sent least-significant bit first, at one bit per symbol if `pay_2m` was 0 at start and two bits per symbol if it was 1. `s_ready` is high only in a `chip_en` cycle that opens the first symbol of a byte.
- R11: If `s_valid` is low when `s_ready` is high, the frame ends: `busy` falls and no further chips are produced.
- R12: The phase is 0° before the first symbol of every frame, so equal start inputs give equal chip streams.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_en | input | 1 | One-cycle chip-rate enable |
| start | input | 1 | Frame start pulse |
| seed | input | 7 | Scrambler initial state |
| hdr_word | input | 48 | Header bits, bit 0 sent first |
| pay_2m | input | 1 | Payload rate: 1 selects two bits per symbol |
| s_valid | input | 1 | Payload byte offered |
| s_data | input | 8 | Payload byte |
| s_ready | output | 1 | Payload byte taken this cycle |
| busy | output | 1 | Frame in progress |
| chip_valid | output | 1 | Chip pair valid |
| chip_i | output | 1 | In-phase chip (1 = +1) |
| chip_q | output | 1 | Quadrature chip (1 = +1) |

## Verification
The assertions assume synchronous inputs. They assume `chip_en` is a level sampled each cycle, and that `rst` is held for at least one edge before any checked activity. They also assume `s_data` does not change while `s_valid` waits for a slot, because the ready/stop decision is made in the slot cycle itself. The stimulus drives every input on the falling clock edge. It holds `s_valid` and `s_data` steady until the handshake edge and drops `s_valid` only after the last byte. It spaces `chip_en` one, two or three cycles apart so that slots fall in different phases of the clock.

// File: rtl/dsss_tx_pkg.sv
package dsss_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SYNC,
        ST_SFD,
        ST_HDR,
        ST_PAY
    } frame_st_e;

    typedef logic [1:0] phase_t;   // 0:0deg 1:90deg 2:180deg 3:270deg

    typedef struct packed {
        logic       two;    // 1: two bits in this symbol
        logic [1:0] bits;   // bits[0] is the earlier bit
    } sym_t;

    // differential QPSK phase increment for a scrambled pair
    function automatic phase_t dq_delta(input logic first, input logic second);
        case ({first, second})
            2'b00:   return 2'd0;
            2'b01:   return 2'd1;
            2'b11:   return 2'd2;
            default: return 2'd3;
        endcase
    endfunction

    // sign of I (bit 1) and Q (bit 0) for a phase, 1 = positive
    function automatic logic [1:0] iq_of(input phase_t p);
        case (p)
            2'd0:    return 2'b11;
            2'd1:    return 2'b01;
            2'd2:    return 2'b00;
            default: return 2'b10;
        endcase
    endfunction

endpackage

// File: rtl/dsss_tx_seq.sv
module dsss_tx_seq
    import dsss_tx_pkg::*;
#(
    parameter int              SYNC_SYMS = 56,
    parameter int              SFD_W     = 16,
    parameter logic [SFD_W-1:0] SFD_WORD = 16'h05CF,
    parameter int              HDR_W     = 48,
    parameter int              BYTE_W    = 8,
    parameter int              PN_LEN    = 11,
    localparam int             CHIP_W    = $clog2(PN_LEN),
    localparam int             CNT_W     = $clog2(SYNC_SYMS + SFD_W + HDR_W + BYTE_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chip_en,
    input  logic              start,
    input  logic [HDR_W-1:0]  hdr_word,
    input  logic              pay_2m,
    input  logic              s_valid,
    input  logic [BYTE_W-1:0] s_data,
    output logic              s_ready,
    output logic              busy,
    output logic              frame_start,
    output logic              sym_go,
    output sym_t              sym,
    output logic              chip_fire,
    output logic [CHIP_W-1:0] chip_idx
);

    frame_st_e         st_q, st_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [CHIP_W-1:0] chip_q;
    logic [HDR_W-1:0]  hdr_q;
    logic [SFD_W-1:0]  sfd_q;
    logic [BYTE_W-1:0] byte_q, byte_src;
    logic              p2m_q;
    logic              slot, byte_due, stop, last;

    assign busy        = (st_q != ST_IDLE);
    assign frame_start = (st_q == ST_IDLE) && start;
    assign slot        = chip_en && busy && (chip_q == '0);
    assign byte_due    = (st_q == ST_PAY) && (cnt_q == '0);
    assign s_ready     = slot && byte_due;
    assign stop        = s_ready && !s_valid;
    assign sym_go      = slot && !stop;
    assign chip_fire   = chip_en && busy && !stop;
    assign chip_idx    = chip_q;
    assign byte_src    = byte_due ? s_data : byte_q;

    always_comb begin
        sym  = '0;
        last = 1'b0;
        st_d = st_q;
        case (st_q)
            ST_SYNC: begin
                last = (cnt_q == CNT_W'(SYNC_SYMS - 1));
                if (last) st_d = ST_SFD;
            end
            ST_SFD: begin
                sym.bits = {1'b0, sfd_q[0]};
                last     = (cnt_q == CNT_W'(SFD_W - 1));
                if (last) st_d = ST_HDR;
            end
            ST_HDR: begin
                sym.two  = 1'b1;
                sym.bits = hdr_q[1:0];
                last     = (cnt_q == CNT_W'(HDR_W / 2 - 1));
                if (last) st_d = ST_PAY;
            end
            ST_PAY: begin
                sym.two  = p2m_q;
                sym.bits = p2m_q ? byte_src[1:0] : {1'b0, byte_src[0]};
                last     = p2m_q ? (cnt_q == CNT_W'(BYTE_W / 2 - 1))
                                 : (cnt_q == CNT_W'(BYTE_W - 1));
            end
            default: ;
        endcase
        cnt_d = last ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            cnt_q  <= '0;
            chip_q <= '0;
            hdr_q  <= '0;
            sfd_q  <= '0;
            byte_q <= '0;
            p2m_q  <= 1'b0;
        end else if (st_q == ST_IDLE) begin
            if (start) begin
                st_q   <= ST_SYNC;
                cnt_q  <= '0;
                chip_q <= '0;
                hdr_q  <= hdr_word;
                sfd_q  <= SFD_WORD;
                p2m_q  <= pay_2m;
            end
        end else if (chip_en) begin
            if (stop) begin
                st_q   <= ST_IDLE;
                chip_q <= '0;
            end else begin
                chip_q <= (chip_q == CHIP_W'(PN_LEN - 1)) ? '0 : chip_q + 1'b1;
                if (slot) begin
                    st_q  <= st_d;
                    cnt_q <= cnt_d;
                    if (st_q == ST_SFD) sfd_q <= sfd_q >> 1;
                    if (st_q == ST_HDR) hdr_q <= hdr_q >> 2;
                    if (st_q == ST_PAY) byte_q <= p2m_q ? (byte_src >> 2) : (byte_src >> 1);
                end
            end
        end
    end

    // R10: a byte is only taken on a chip slot of a running frame
    a_r10_ready_on_slot: assert property (@(posedge clk) disable iff (rst)
        s_ready |-> (chip_en && busy));

    // R3: chip position never leaves the spreading length
    a_r3_chip_range: assert property (@(posedge clk) disable iff (rst)
        chip_q <= CHIP_W'(PN_LEN - 1));

    // R6: the delimiter section is entered only from the sync section
    a_r6_sfd_after_sync: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_SFD && $past(st_q) != ST_SFD) |-> $past(st_q) == ST_SYNC);

    // R11: a frame only ends from the payload section
    a_r11_end_from_payload: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_IDLE && $past(st_q) != ST_IDLE) |-> $past(st_q) == ST_PAY);

endmodule

// File: rtl/dsss_tx_diffenc.sv
module dsss_tx_diffenc
    import dsss_tx_pkg::*;
#(
    parameter int SCR_W = 7,
    parameter int TAP_A = 4,
    parameter int TAP_B = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_start,
    input  logic [SCR_W-1:0] seed,
    input  logic             sym_go,
    input  sym_t             sym,
    output phase_t           phase_now
);

    logic [SCR_W-1:0] scr_q, scr_mid, scr_d;
    logic             s0, s1;
    phase_t           ph_q, ph_d, delta;

    always_comb begin
        s0      = sym.bits[0] ^ scr_q[TAP_A-1] ^ scr_q[TAP_B-1];
        scr_mid = {scr_q[SCR_W-2:0], s0};
        s1      = sym.bits[1] ^ scr_mid[TAP_A-1] ^ scr_mid[TAP_B-1];
        scr_d   = sym.two ? {scr_mid[SCR_W-2:0], s1} : scr_mid;
        delta   = sym.two ? dq_delta(s0, s1) : {s0, 1'b0};
        ph_d    = ph_q + delta;
    end

    assign phase_now = sym_go ? ph_d : ph_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scr_q <= '0;
            ph_q  <= '0;
        end else if (frame_start) begin
            scr_q <= seed;
            ph_q  <= '0;
        end else if (sym_go) begin
            scr_q <= scr_d;
            ph_q  <= ph_d;
        end
    end

    // R8: a one-bit symbol moves the phase by 0 or 180 degrees only
    a_r8_dbpsk_step: assert property (@(posedge clk) disable iff (rst)
        (sym_go && !sym.two && !frame_start) |=> ph_q[0] == $past(ph_q[0]));

endmodule

// File: rtl/dsss_tx_spread.sv
module dsss_tx_spread
    import dsss_tx_pkg::*;
#(
    parameter int              PN_LEN = 11,
    parameter logic [PN_LEN-1:0] PN_SEQ = 11'h0ED,
    localparam int             CHIP_W = $clog2(PN_LEN)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chip_fire,
    input  logic [CHIP_W-1:0] chip_idx,
    input  phase_t            phase_now,
    output logic              chip_valid,
    output logic              chip_i,
    output logic              chip_q
);

    logic       pn;
    logic [1:0] iq;

    assign pn = PN_SEQ[chip_idx];
    assign iq = iq_of(phase_now);

    always_ff @(posedge clk) begin
        if (rst) begin
            chip_valid <= 1'b0;
            chip_i     <= 1'b0;
            chip_q     <= 1'b0;
        end else begin
            chip_valid <= chip_fire;
            if (chip_fire) begin
                chip_i <= ~(iq[1] ^ pn);
                chip_q <= ~(iq[0] ^ pn);
            end
        end
    end

endmodule

// File: rtl/dsss_lr_tx.sv
module dsss_lr_tx
    import dsss_tx_pkg::*;
#(
    parameter int SYNC_SYMS = 56,
    parameter int HDR_W     = 48,
    parameter int SCR_W     = 7,
    parameter int BYTE_W    = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chip_en,
    input  logic              start,
    input  logic [SCR_W-1:0]  seed,
    input  logic [HDR_W-1:0]  hdr_word,
    input  logic              pay_2m,
    input  logic              s_valid,
    input  logic [BYTE_W-1:0] s_data,
    output logic              s_ready,
    output logic              busy,
    output logic              chip_valid,
    output logic              chip_i,
    output logic              chip_q
);

    localparam int PN_LEN = 11;
    localparam int CHIP_W = $clog2(PN_LEN);

    logic              frame_start, sym_go, chip_fire;
    logic [CHIP_W-1:0] chip_idx;
    sym_t              sym;
    phase_t            phase_now;

    dsss_tx_seq #(
        .SYNC_SYMS(SYNC_SYMS), .SFD_W(16), .SFD_WORD(16'h05CF),
        .HDR_W(HDR_W), .BYTE_W(BYTE_W), .PN_LEN(PN_LEN)
    ) u_seq (
        .clk(clk), .rst(rst), .chip_en(chip_en), .start(start),
        .hdr_word(hdr_word), .pay_2m(pay_2m), .s_valid(s_valid),
        .s_data(s_data), .s_ready(s_ready), .busy(busy),
        .frame_start(frame_start), .sym_go(sym_go), .sym(sym),
        .chip_fire(chip_fire), .chip_idx(chip_idx)
    );

    dsss_tx_diffenc #(.SCR_W(SCR_W), .TAP_A(4), .TAP_B(7)) u_enc (
        .clk(clk), .rst(rst), .frame_start(frame_start), .seed(seed),
        .sym_go(sym_go), .sym(sym), .phase_now(phase_now)
    );

    dsss_tx_spread #(.PN_LEN(PN_LEN), .PN_SEQ(11'h0ED)) u_spread (
        .clk(clk), .rst(rst), .chip_fire(chip_fire), .chip_idx(chip_idx),
        .phase_now(phase_now), .chip_valid(chip_valid),
        .chip_i(chip_i), .chip_q(chip_q)
    );

    // R3: every chip pair follows a chip enable by one cycle
    a_r3_valid_after_enable: assert property (@(posedge clk) disable iff (rst)
        chip_valid |-> $past(chip_en));

    // R1/R11: no chip is produced outside a frame
    a_r11_no_chip_when_idle: assert property (@(posedge clk) disable iff (rst)
        chip_valid |-> $past(busy));

endmodule

// File: tb/dsss_lr_tx_test.sv
`timescale 1ns/1ps
module dsss_lr_tx_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        chip_en = 1'b0;
    logic        start = 1'b0;
    logic [6:0]  seed_i = '0;
    logic [47:0] hdr_i = '0;
    logic        pay_i = 1'b0;
    logic        s_valid = 1'b0;
    logic [7:0]  s_data = '0;
    logic        s_ready, busy, chip_valid, chip_i, chip_q;

    dsss_lr_tx uut (
        .clk(clk), .rst(rst), .chip_en(chip_en), .start(start), .seed(seed_i),
        .hdr_word(hdr_i), .pay_2m(pay_i), .s_valid(s_valid), .s_data(s_data),
        .s_ready(s_ready), .busy(busy), .chip_valid(chip_valid),
        .chip_i(chip_i), .chip_q(chip_q)
    );

    always #4 clk = ~clk;   // 125 MHz

    int          total = 0;
    int          bad = 0;
    int          ce_div = 2;
    int          fed = 0;
    string       note = "";
    logic [1:0]  exp_q[$];
    string       tag_q[$];
    logic [7:0]  byte_mem[16];
    logic [6:0]  m_sr;
    int          m_ph;
    bit          pn_b[11] = '{1, 0, 1, 1, 0, 1, 1, 1, 0, 0, 0};

    task automatic check(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // ---------------- reference model (from the requirements) ----------------
    function automatic logic [1:0] ref_iq(input int ph);
        case (ph)
            0: return 2'b11;
            1: return 2'b01;
            2: return 2'b00;
            default: return 2'b10;
        endcase
    endfunction

    task automatic ref_scr(input bit d, output bit s);
        s = d ^ m_sr[3] ^ m_sr[6];
        m_sr = {m_sr[5:0], s};
    endtask

    task automatic push_chips(input string t);
        logic [1:0] iq;
        iq = ref_iq(m_ph);
        for (int c = 0; c < 11; c++) begin
            exp_q.push_back({~(iq[1] ^ pn_b[c]), ~(iq[0] ^ pn_b[c])});
            tag_q.push_back(t);
        end
    endtask

    task automatic sym1(input bit d, input string t);
        bit s;
        ref_scr(d, s);
        if (s) m_ph = (m_ph + 2) % 4;
        push_chips(t);
    endtask

    task automatic sym2(input bit d0, input bit d1, input string t);
        bit s0, s1;
        int dl;
        ref_scr(d0, s0);
        ref_scr(d1, s1);
        case ({s0, s1})
            2'b00: dl = 0;
            2'b01: dl = 1;
            2'b11: dl = 2;
            default: dl = 3;
        endcase
        m_ph = (m_ph + dl) % 4;
        push_chips(t);
    endtask

    task automatic build(input logic [6:0] sd, input logic [47:0] hd, input bit p2m, input int nb);
        logic [15:0] sfd = 16'h05CF;
        m_sr = sd;
        m_ph = 0;
        for (int k = 0; k < 56; k++) sym1(1'b0, "R3 R4 R5 R8 sync");
        for (int k = 0; k < 16; k++) sym1(sfd[k], "R3 R4 R6 R8 delimiter");
        for (int k = 0; k < 24; k++) sym2(hd[2*k], hd[2*k+1], "R3 R7 R9 header");
        for (int b = 0; b < nb; b++) begin
            if (p2m) begin
                for (int k = 0; k < 4; k++) sym2(byte_mem[b][2*k], byte_mem[b][2*k+1], "R10 R9 payload");
            end else begin
                for (int k = 0; k < 8; k++) sym1(byte_mem[b][k], "R10 R8 payload");
            end
        end
    endtask

    // ---------------- stimulus ----------------
    initial begin
        int ce_cnt = 0;
        forever begin
            @(negedge clk);
            if (ce_div <= 1) chip_en = 1'b1;
            else begin
                ce_cnt = (ce_cnt + 1) % ce_div;
                chip_en = (ce_cnt == 0);
            end
        end
    end

    task automatic feed(input int nb);
        for (int b = 0; b < nb; b++) begin
            s_data  = byte_mem[b];
            s_valid = 1'b1;
            do begin
                @(negedge clk);
                #1;
            end while (!s_ready);
            @(posedge clk);
            #1;
            fed++;
        end
        s_valid = 1'b0;
    endtask

    // ---------------- monitor / scoreboard ----------------
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && chip_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R11 chip after frame end", 1, 0);
                end else begin
                    logic [1:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check({chip_i, chip_q} == e, {t, note}, int'({chip_i, chip_q}), int'(e));
                end
            end
        end
    end

    task automatic run_frame(input logic [6:0] sd, input logic [47:0] hd, input bit p2m,
                             input int nb, input int div, input string nt, input bit restart);
        int guard;
        ce_div = div;
        note = nt;
        fed = 0;
        build(sd, hd, p2m, nb);
        @(negedge clk);
        seed_i = sd; hdr_i = hd; pay_i = p2m; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        fork
            feed(nb);
        join_none
        if (restart) begin
            repeat (300) @(negedge clk);
            seed_i = ~sd; hdr_i = ~hd; pay_i = ~p2m; start = 1'b1;   // R2: ignored
            @(negedge clk);
            start = 1'b0;
        end
        guard = 0;
        while (busy && guard < 40000) begin
            @(negedge clk);
            guard++;
        end
        repeat (40) @(negedge clk);
        check(busy == 1'b0, {"R11 busy low after frame", nt}, int'(busy), 0);
        check(exp_q.size() == 0, {"R11 all chips delivered", nt}, exp_q.size(), 0);
        check(fed == nb, {"R10 bytes taken", nt}, fed, nb);
        check(s_ready == 1'b0, {"R10 no ready while idle", nt}, int'(s_ready), 0);
        exp_q.delete();
        tag_q.delete();
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(chip_valid == 1'b0, "R1 chip_valid after reset", int'(chip_valid), 0);
        check(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
        check(s_ready == 1'b0, "R1 s_ready after reset", int'(s_ready), 0);

        byte_mem[0] = 8'hA7; byte_mem[1] = 8'h3C; byte_mem[2] = 8'hF0;
        byte_mem[3] = 8'h1E; byte_mem[4] = 8'h00; byte_mem[5] = 8'hFF;
        run_frame(7'h5D, 48'hA53C_0FF0_9671, 1'b0, 3, 2, " frame1", 1'b0);

        byte_mem[0] = 8'h5A; byte_mem[1] = 8'hC3; byte_mem[2] = 8'h81; byte_mem[3] = 8'h7E;
        run_frame(7'h01, 48'h1234_5678_9ABC, 1'b1, 4, 1, " frame2 R2", 1'b1);

        run_frame(7'h7F, 48'hFFFF_0000_F0F0, 1'b1, 0, 3, " frame3 empty payload", 1'b0);

        byte_mem[0] = 8'hA7; byte_mem[1] = 8'h3C;
        run_frame(7'h5D, 48'hA53C_0FF0_9671, 1'b0, 2, 2, " frame4 R12", 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (180000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule